// File: doc/BRIEF.md
# Trigger Pulse Generator

The block turns each accepted event strobe into one output trigger pulse. The pulse has a programmable delay and a programmable width. Both are counted in one shared time unit. The unit is either a prescaled fraction of the 40 MHz system clock (25 ns, 50 ns or 100 ns) or the rising edge of an asynchronous external tick. A single configuration word supplies the delay, the width and the unit choice. The block samples that word when a strobe is accepted, so a change made during an event does not alter that event.

While an event is in progress (from acceptance through the end of its pulse), the busy output is high and further strobes are dropped. A width of zero discards the event at once: no pulse is produced and busy stays low. The prescaler restarts on every accepted strobe, so in the clock-derived units the pulse timing relative to the strobe is exact to the cycle.

Top module: `trigPulseGen`

## Requirements
- R1: While reset is asserted and right after it is released, trigOut and busy are 0.
- R2: With unit field cfgWord[9:8] = 0, one time unit equals one clock cycle. For delay D and width W, the pulse goes high (D+1) cycles after the accepting clock edge and stays high for W cycles.
- R3: With unit field 1 one unit is 2 cycles, and with unit field 2 it is 4 cycles. The prescaler restarts at the accepting edge, so the pulse starts (D+1)·N cycles after that edge and lasts W·N cycles, where N is the unit length in cycles.
- R4: With unit field 3, each rising edge of extTick, after a two-flop synchroniser and an edge detector, supplies one unit. A tick edge that arrives between clock edges is consumed on the third clock edge after it.
- R5: The delay field cfgWord[7:4] counts units before the pulse. The pulse starts on the (D+1)-th unit, so a delay of 0 starts it on the first unit after acceptance. The pulse never starts in the cycle in which busy rises.
- R6: The width field cfgWord[3:0] gives the pulse length in units (1 to 15). A strobe seen with a width of 0 produces no pulse and leaves busy low.
- R7: Busy rises on the clock edge that accepts a strobe and falls on the same edge on which the pulse ends. trigOut is only high while busy is high.
- R8: A strobe that arrives while busy is high has no effect, even in the last busy cycle. The running pulse keeps its timing and no second pulse follows.
- R9: Delay, width and unit are captured from cfgWord on the accepting edge. Changing cfgWord during an event changes neither the timing of that event nor its unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rstN | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Event strobe, accepted when high at a clock edge while idle |
| extTick | input | 1 | Asynchronous external time-unit tick; its rising edges count in unit 3 |
| cfgWord | input | 10 | [3:0] width in units, [7:4] delay in units, [9:8] unit select |
| trigOut | output | 1 | Output trigger pulse |
| busy | output | 1 | High from acceptance of a strobe until the pulse ends |

## Verification
The scoreboard measures three intervals for every event, counted in clock cycles from the accepting edge: the start of the pulse, its length and the length of busy. A fault in the prescaler phase, the delay counter or the width counter shows at once as one of these numbers being off by a whole unit. A fault in the captured configuration shows as intervals that follow the rewritten cfgWord instead of the value captured at the strobe. A fault in the idle or acceptance logic shows within a few cycles after busy falls, as a stray pulse or as busy staying high during the quiet window that follows each event.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    UNIT_25NS  = 2'd0,
    UNIT_50NS  = 2'd1,
    UNIT_100NS = 2'd2,
    UNIT_EXT   = 2'd3
  } unitSel_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_PULSE = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture configuration, restart prescaler
    logic run;        // timebase active
    logic delayDec;   // consume one delay unit
    logic widthLoad;  // arm width counter
    logic widthDec;   // consume one width unit
  } ctrlStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic unitEn;
    logic delayDone;
    logic widthLast;
  } dpStat_t;

endpackage

// File: rtl/trigTimebase.sv
module trigTimebase #(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extTick,
  input  logic               restart,
  input  logic               run,
  input  trig_pkg::unitSel_e unitSel,
  output logic               unitEn
);
  import trig_pkg::*;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   tickPrev;
  logic                   extRise;
  logic [PRE_W-1:0]       prescCnt;
  logic [PRE_W-1:0]       divMax;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= extTick;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) tickPrev <= 1'b0;
    else       tickPrev <= syncQ[SYNC_STAGES-1];
  end

  assign extRise = syncQ[SYNC_STAGES-1] & ~tickPrev;

  always_comb begin
    case (unitSel)
      UNIT_50NS:  divMax = PRE_W'(1);
      UNIT_100NS: divMax = PRE_W'(3);
      default:    divMax = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || restart)       prescCnt <= '0;
    else if (run) begin
      if (prescCnt == divMax)   prescCnt <= '0;
      else                      prescCnt <= prescCnt + PRE_W'(1);
    end
  end

  assign unitEn = run & ((unitSel == UNIT_EXT) ? extRise : (prescCnt == divMax));

endmodule

// File: rtl/trigDatapath.sv
module trigDatapath #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                extTick,
  input  logic [CNT_W-1:0]    cfgDelay,
  input  logic [CNT_W-1:0]    cfgWidth,
  input  trig_pkg::unitSel_e  cfgUnit,
  input  trig_pkg::ctrlStrb_t ctrl,
  output trig_pkg::dpStat_t   stat
);
  import trig_pkg::*;

  logic [CNT_W-1:0] delayCnt;
  logic [CNT_W-1:0] widthSet;
  logic [CNT_W-1:0] widthCnt;
  unitSel_e         unitReg;
  logic             unitEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayCnt <= '0;
      widthSet <= '0;
      unitReg  <= UNIT_25NS;
    end else if (ctrl.load) begin
      delayCnt <= cfgDelay;
      widthSet <= cfgWidth;
      unitReg  <= cfgUnit;
    end else if (ctrl.delayDec) begin
      delayCnt <= delayCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               widthCnt <= '0;
    else if (ctrl.widthLoad) widthCnt <= widthSet;
    else if (ctrl.widthDec)  widthCnt <= widthCnt - CNT_W'(1);
  end

  trigTimebase #(
    .SYNC_STAGES(SYNC_STAGES),
    .PRE_W      (PRE_W)
  ) u_timebase (
    .clk    (clk),
    .rstN   (rstN),
    .extTick(extTick),
    .restart(ctrl.load),
    .run    (ctrl.run),
    .unitSel(unitReg),
    .unitEn (unitEn)
  );

  assign stat.unitEn    = unitEn;
  assign stat.delayDone = (delayCnt == '0);
  assign stat.widthLast = (widthCnt == CNT_W'(1));

endmodule

// File: rtl/trigControl.sv
module trigControl #(
  parameter int CNT_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                strobe,
  input  logic [CNT_W-1:0]    cfgWidth,
  input  trig_pkg::dpStat_t   stat,
  output trig_pkg::ctrlStrb_t ctrl,
  output logic                busy,
  output logic                trigOut
);
  import trig_pkg::*;

  phase_e phase;
  phase_e phaseNext;

  always_comb begin
    ctrl      = '0;
    phaseNext = phase;
    ctrl.run  = (phase != PH_IDLE);
    case (phase)
      PH_IDLE: begin
        if (strobe && (cfgWidth != '0)) begin
          ctrl.load = 1'b1;
          phaseNext = PH_DELAY;
        end
      end
      PH_DELAY: begin
        if (stat.unitEn) begin
          if (stat.delayDone) begin
            ctrl.widthLoad = 1'b1;
            phaseNext      = PH_PULSE;
          end else begin
            ctrl.delayDec = 1'b1;
          end
        end
      end
      PH_PULSE: begin
        if (stat.unitEn) begin
          if (stat.widthLast) phaseNext = PH_IDLE;
          else                ctrl.widthDec = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign busy    = (phase != PH_IDLE);
  assign trigOut = (phase == PH_PULSE);

endmodule

// File: rtl/trigPulseGen.sv
module trigPulseGen #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               strobe,
  input  logic               extTick,
  input  logic [2*CNT_W+1:0] cfgWord,
  output logic               trigOut,
  output logic               busy
);
  import trig_pkg::*;

  localparam int PRE_W = 2;  // prescale up to divide-by-4

  logic [CNT_W-1:0] cfgWidth;
  logic [CNT_W-1:0] cfgDelay;
  unitSel_e         cfgUnit;
  ctrlStrb_t        ctrl;
  dpStat_t          stat;

  assign cfgWidth = cfgWord[CNT_W-1:0];
  assign cfgDelay = cfgWord[2*CNT_W-1:CNT_W];
  assign cfgUnit  = unitSel_e'(cfgWord[2*CNT_W+1:2*CNT_W]);

  trigControl #(.CNT_W(CNT_W)) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgWidth(cfgWidth),
    .stat    (stat),
    .ctrl    (ctrl),
    .busy    (busy),
    .trigOut (trigOut)
  );

  trigDatapath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES),
    .PRE_W      (PRE_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .extTick (extTick),
    .cfgDelay(cfgDelay),
    .cfgWidth(cfgWidth),
    .cfgUnit (cfgUnit),
    .ctrl    (ctrl),
    .stat    (stat)
  );

endmodule

// File: rtl/trigPulseGen_checker.sv
module trigPulseGen_checker #(
  parameter int CNT_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               strobe,
  input logic [2*CNT_W+1:0] cfgWord,
  input logic               trigOut,
  input logic               busy
);

  // R7: pulse only inside busy
  assert_pulse_in_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> busy);

  // R7: busy ends together with the pulse
  assert_busy_ends_with_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trigOut) |-> !busy);

  // R5: the pulse never begins in the acceptance cycle
  assert_no_zero_delay_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !trigOut);

  // R5: a delay phase always precedes the pulse
  assert_delay_precedes_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigOut) |-> $past(busy));

  // R6: zero width leaves the block idle
  assert_zero_width_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && strobe && (cfgWord[CNT_W-1:0] == '0)) |=> !busy);

endmodule

bind trigPulseGen trigPulseGen_checker #(.CNT_W(CNT_W)) u_checker (
  .clk    (clk),
  .rstN   (rstN),
  .strobe (strobe),
  .cfgWord(cfgWord),
  .trigOut(trigOut),
  .busy   (busy)
);

// File: tb/trigPulseGen_bench.sv
`timescale 1ns/1ps
module trigPulseGen_bench;

  localparam int CLK_PERIOD = 25;
  localparam int CNT_W      = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               strobe = 1'b0;
  logic               extTick = 1'b0;
  logic [2*CNT_W+1:0] cfgWord = '0;
  logic               trigOut;
  logic               busy;

  typedef struct {
    int    rise;
    int    len;
    int    busyLen;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int   vecCnt  = 0;
  int   errCnt  = 0;
  int   issued  = 0;
  int   doneCnt = 0;
  event capEv;

  always #(CLK_PERIOD/2.0) clk = ~clk;

  trigPulseGen #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_trigPulseGen (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .extTick(extTick),
    .cfgWord(cfgWord),
    .trigOut(trigOut),
    .busy   (busy)
  );

  task automatic check(string what, int act, int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic tickGen(int n);
    for (int k = 0; k < n; k++) begin
      extTick = 1'b1;
      repeat (2) @(negedge clk);
      extTick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  // driver: push expectation, apply strobe, optional disturbances
  task automatic runEvent(int d, int w, int u, bit midChg, int extraAt, string tag);
    exp_t e;
    int   quiet;
    if (w == 0) begin
      e.rise = 0; e.len = 0; e.busyLen = 0;
    end else if (u < 3) begin
      e.rise    = (d + 1) * (1 << u) + 1;
      e.len     = w * (1 << u);
      e.busyLen = (d + 1 + w) * (1 << u);
    end else begin
      e.rise    = 4 + 5 * d;
      e.len     = 5 * w;
      e.busyLen = 3 + 5 * (d + w);
    end
    e.tag = tag;
    expQ.push_back(e);
    issued++;
    @(negedge clk);
    cfgWord = {2'(u), 4'(d), 4'(w)};
    strobe  = 1'b1;
    @(posedge clk);
    ->capEv;
    for (int s = 1; s <= e.busyLen + 1; s++) begin
      @(negedge clk);
      strobe = (s == extraAt);
      if (s == 1 && u == 3 && w != 0) begin
        fork
          tickGen(d + w + 1);
        join_none
      end
      if (s == 2 && midChg) cfgWord = ~cfgWord;
    end
    strobe = 1'b0;
    wait (doneCnt == issued);
    quiet = 1;
    for (int g = 0; g < 14; g++) begin
      @(negedge clk);
      if (trigOut || busy) quiet = 0;
    end
    check({tag, " R8 quiet after event"}, quiet, 1);
  endtask

  // monitor: measure each event against the scoreboard
  initial begin
    forever begin
      exp_t e;
      int   sample;
      int   rise;
      int   len;
      int   bLen;
      @(capEv);
      e = expQ.pop_front();
      sample = 0; rise = 0; len = 0; bLen = 0;
      forever begin
        @(negedge clk);
        sample++;
        if (trigOut) begin
          if (rise == 0) rise = sample;
          len++;
        end
        if (busy) bLen++;
        if (!busy || sample > 2000) break;
      end
      check({e.tag, " R5 pulse start"}, rise, e.rise);
      check({e.tag, " R6 pulse length"}, len, e.len);
      check({e.tag, " R7 busy length"}, bLen, e.busyLen);
      doneCnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 trigOut in reset", int'(trigOut), 0);
    check("R1 busy in reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 trigOut after reset", int'(trigOut), 0);
    check("R1 busy after reset", int'(busy), 0);

    runEvent(0, 1, 0, 0, 0, "R2 d0 w1");
    runEvent(0, 15, 0, 0, 0, "R2 d0 w15");
    runEvent(15, 15, 0, 0, 0, "R2 d15 w15");
    runEvent(3, 2, 1, 0, 0, "R3 unit50 d3 w2");
    runEvent(2, 5, 2, 0, 0, "R3 unit100 d2 w5");
    runEvent(15, 15, 2, 0, 0, "R3 unit100 d15 w15");
    runEvent(0, 0, 0, 0, 0, "R6 zero width");
    runEvent(5, 0, 2, 0, 0, "R6 zero width unit100");
    runEvent(4, 3, 0, 1, 0, "R9 cfg change");
    runEvent(6, 4, 1, 0, 3, "R8 strobe in delay");
    runEvent(2, 3, 0, 0, 6, "R8 strobe last busy cycle");
    runEvent(0, 1, 3, 0, 0, "R4 ext d0 w1");
    runEvent(3, 4, 3, 0, 0, "R4 ext d3 w4");
    runEvent(2, 2, 3, 1, 0, "R9 ext cfg change");
    runEvent(1, 2, 2, 1, 4, "R9 unit100 change");

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule